// File: doc/BRIEF.md
# Write Buffer with Read-Match Stall

This block sits beside a write-through, no-write-allocate first-level data cache and in front of a write-back second-level cache. Requests from the first level enter an input queue. Stores and read-modify-writes move from that queue into a small FIFO of pending writes. Every other request travels on a separate read lane towards the second-level request queue.

A read whose first-level block is still held in the write FIFO is not answered from the buffer. It waits at the head of the input queue until that write has drained. A snoop port checks coherence requests against the buffered writes at the coarser second-level block size, and marks the entry it hits. The block reports its occupancy, the number of marked entries, and two stall counters.

The second-level queue reports how many free slots it has. In each cycle the oldest buffered write takes a slot first. A read may then use a slot that is still free.

Top module: `l1_write_buffer`

## Requirements
- R1: After reset, `req_ready_o` is 1. `occ_o`, `cohe_cnt_o`, `stall_full_o` and `stall_match_o` are 0. Both lanes to the second level are idle.
- R2: A request is buffered as a write only when `req_kind_i` is 1 (store) or 2 (read-modify-write) and `req_pf_i` is 0. Kind 0 (read), kind 3 (other), and any request with `req_pf_i`=1 go out on the read lane with their kind and prefetch bit unchanged.
- R3: The write FIFO holds at most 8 entries. The input queue holds 32. `req_ready_o` is 0 exactly when the input queue is full.
- R4: When `occ_o` is non-zero and `l2_space_i` is non-zero, the oldest buffered write appears on the write lane in that same cycle. Writes leave in arrival order, each with its address, its data, and a read-modify-write flag.
- R5: A read is forwarded only when a slot remains after the drain. That takes `l2_space_i`>=2 when a write drains in the same cycle, or `l2_space_i`>=1 when none does. Otherwise the read waits.
- R6: A read whose address matches a buffered write above bit 5 (a 32-byte first-level block) stays at the head of the queue and gets no data. `stall_match_o` rises by one in each cycle it is held. A read to a different block is not held.
- R7: A read that matches only the write draining in the current cycle is treated as unmatched. It may go out in that same cycle, behind the write.
- R8: A write at the head of the input queue that finds the FIFO full, with no drain in that cycle, stays where it is. `stall_full_o` rises by one in each such cycle. When a drain frees a slot, the write enters the FIFO in that same cycle.
- R9: `snoop_hit_o` is combinational. It is 1 when `snoop_valid_i` is 1 and `snoop_addr_i` matches a buffered, non-draining write above bit 7 (a 128-byte second-level block). A hit marks the oldest such entry. `cohe_cnt_o` rises by one only when that entry was not already marked.
- R10: When a marked entry drains, its mark is cleared and `cohe_cnt_o` falls by one. A newly buffered write starts unmarked.
- R11: `occ_o` rises by one when a write enters the FIFO and falls by one when a write drains. It changes by at most one per cycle.
- R12: Requests leave the input queue in arrival order. A write queued behind a blocked read stays behind it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered from the first level |
| req_ready_o | output | 1 | Input queue can accept a request |
| req_kind_i | input | 2 | Request kind: 0 read, 1 store, 2 read-modify-write, 3 other |
| req_pf_i | input | 1 | Request is a prefetch |
| req_addr_i | input | AW | Request byte address |
| req_data_i | input | DW | Store data |
| l2_space_i | input | 2 | Free second-level slots: 0, 1, or 2 and more (2 or 3) |
| l2_wr_valid_o | output | 1 | Buffered write issued to the second level |
| l2_wr_rmw_o | output | 1 | Issued write is a read-modify-write |
| l2_wr_addr_o | output | AW | Issued write address |
| l2_wr_data_o | output | DW | Issued write data |
| l2_rd_valid_o | output | 1 | Read-lane request issued to the second level |
| l2_rd_kind_o | output | 2 | Kind of the read-lane request |
| l2_rd_pf_o | output | 1 | Prefetch bit of the read-lane request |
| l2_rd_addr_o | output | AW | Read-lane request address |
| l2_rd_data_o | output | DW | Data carried by the read-lane request |
| snoop_valid_i | input | 1 | Coherence lookup present |
| snoop_addr_i | input | AW | Coherence lookup address |
| snoop_hit_o | output | 1 | Lookup matched a buffered write |
| occ_o | output | $clog2(WB_DEPTH+1) | Write FIFO occupancy |
| cohe_cnt_o | output | $clog2(WB_DEPTH+1) | Number of marked entries still buffered |
| stall_full_o | output | CNT_W | Cycles a write was held by a full FIFO |
| stall_match_o | output | CNT_W | Cycles a read was held by an address match |

## Verification
The bench targets the boundaries where the address compares differ. A read one first-level block away from a buffered write must pass it, while a snoop at that same distance must hit. A design that masked both compares the same way would stall the read or miss the snoop.

It also checks a read whose only match is the write draining in the same cycle. That read must leave at once when two slots are free, and wait when only one is free. A design that searched before the drain would stall it, and one that ignored the slot count would overfill the second-level queue.

The full FIFO is driven to the point where a drain and an enqueue share a cycle, and the input queue is driven to its 32nd entry. The test of repeated snoops to an already marked entry would show a counter that double-counts.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    RQ_READ  = 2'd0,
    RQ_STORE = 2'd1,
    RQ_RMW   = 2'd2,
    RQ_OTHER = 2'd3
  } rq_kind_e;

  function automatic logic goes_to_buffer(input logic [1:0] kind, input logic pf);
    return !pf && (kind == RQ_STORE || kind == RQ_RMW);
  endfunction
endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign dout_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= bump(wr_q);
      if (pop_i)  rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= din_i;
  end
endmodule

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int DEPTH  = 8,
  parameter int L1_OFS = 5,
  parameter int L2_OFS = 7
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [AW-1:0]                push_addr_i,
  input  logic [DW-1:0]                push_data_i,
  input  logic                         push_rmw_i,
  input  logic                         pop_i,
  input  logic [AW-1:0]                look_addr_i,
  input  logic                         snoop_valid_i,
  input  logic [AW-1:0]                snoop_addr_i,
  output logic [AW-1:0]                head_addr_o,
  output logic [DW-1:0]                head_data_o,
  output logic                         head_rmw_o,
  output logic [$clog2(DEPTH+1)-1:0]   cnt_o,
  output logic                         look_hit_o,
  output logic                         snoop_hit_o,
  output logic [$clog2(DEPTH+1)-1:0]   cohe_cnt_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] L1_MASK = {AW{1'b1}} << L1_OFS;
  localparam logic [AW-1:0] L2_MASK = {AW{1'b1}} << L2_OFS;

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [DEPTH-1:0] rmw_q, mark_q, live;
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q, cohe_q;
  logic [PW-1:0] sn_idx;
  logic          sn_found;
  logic [DEPTH-1:0] l1_eq;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // entries still present after this cycle's drain
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [PW-1:0] age;
    assign age      = PW'(i) - head_q;
    assign live[i]  = (CW'(age) < cnt_q) && !(pop_i && PW'(i) == head_q);
    assign l1_eq[i] = live[i] && (((addr_q[i] ^ look_addr_i) & L1_MASK) == '0);
  end

  assign look_hit_o = |l1_eq;

  // oldest live entry in the snooped second-level block
  always_comb begin
    sn_found = 1'b0;
    sn_idx   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (!sn_found && live[head_q + PW'(k)] &&
          (((addr_q[head_q + PW'(k)] ^ snoop_addr_i) & L2_MASK) == '0)) begin
        sn_found = 1'b1;
        sn_idx   = head_q + PW'(k);
      end
    end
  end

  logic sn_new, mark_drop;
  assign snoop_hit_o = snoop_valid_i && sn_found;
  assign sn_new      = snoop_hit_o && !mark_q[sn_idx];
  assign mark_drop   = pop_i && mark_q[head_q];

  assign head_addr_o = addr_q[head_q];
  assign head_data_o = data_q[head_q];
  assign head_rmw_o  = rmw_q[head_q];
  assign cnt_o       = cnt_q;
  assign cohe_cnt_o  = cohe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      cohe_q <= '0;
      mark_q <= '0;
    end else begin
      if (pop_i) begin
        head_q         <= bump(head_q);
        mark_q[head_q] <= 1'b0;
      end
      if (snoop_hit_o) mark_q[sn_idx] <= 1'b1;
      if (push_i) begin
        tail_q         <= bump(tail_q);
        mark_q[tail_q] <= 1'b0;
      end
      cnt_q  <= cnt_q + CW'(push_i) - CW'(pop_i);
      cohe_q <= cohe_q + CW'(sn_new) - CW'(mark_drop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[tail_q] <= push_addr_i;
      data_q[tail_q] <= push_data_i;
      rmw_q[tail_q]  <= push_rmw_i;
    end
  end
endmodule

// File: rtl/l1_write_buffer.sv
module l1_write_buffer
  import wbuf_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int WB_DEPTH = 8,
  parameter int IQ_DEPTH = 32,
  parameter int L1_OFS   = 5,
  parameter int L2_OFS   = 7,
  parameter int CNT_W    = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  output logic                          req_ready_o,
  input  logic [1:0]                    req_kind_i,
  input  logic                          req_pf_i,
  input  logic [AW-1:0]                 req_addr_i,
  input  logic [DW-1:0]                 req_data_i,
  input  logic [1:0]                    l2_space_i,
  output logic                          l2_wr_valid_o,
  output logic                          l2_wr_rmw_o,
  output logic [AW-1:0]                 l2_wr_addr_o,
  output logic [DW-1:0]                 l2_wr_data_o,
  output logic                          l2_rd_valid_o,
  output logic [1:0]                    l2_rd_kind_o,
  output logic                          l2_rd_pf_o,
  output logic [AW-1:0]                 l2_rd_addr_o,
  output logic [DW-1:0]                 l2_rd_data_o,
  input  logic                          snoop_valid_i,
  input  logic [AW-1:0]                 snoop_addr_i,
  output logic                          snoop_hit_o,
  output logic [$clog2(WB_DEPTH+1)-1:0] occ_o,
  output logic [$clog2(WB_DEPTH+1)-1:0] cohe_cnt_o,
  output logic [CNT_W-1:0]              stall_full_o,
  output logic [CNT_W-1:0]              stall_match_o
);
  localparam int IQ_W  = AW + DW + 3;
  localparam int OCC_W = $clog2(WB_DEPTH + 1);

  logic [IQ_W-1:0] iq_din, iq_dout;
  logic            iq_empty, iq_full, iq_push, iq_pop;
  logic [1:0]      hd_kind;
  logic            hd_pf;
  logic [AW-1:0]   hd_addr;
  logic [DW-1:0]   hd_data;

  assign iq_din      = {req_kind_i, req_pf_i, req_addr_i, req_data_i};
  assign iq_push     = req_valid_i && !iq_full;
  assign req_ready_o = !iq_full;
  assign {hd_kind, hd_pf, hd_addr, hd_data} = iq_dout;

  wbuf_fifo #(.W(IQ_W), .DEPTH(IQ_DEPTH)) u_inq (
    .clk_i, .rst_ni,
    .push_i(iq_push), .din_i(iq_din),
    .pop_i(iq_pop), .dout_o(iq_dout),
    .empty_o(iq_empty), .full_o(iq_full)
  );

  logic             drain, wr_take, rd_fwd, rd_room, look_hit;
  logic             hd_valid, hd_is_wr;
  logic [OCC_W-1:0] st_cnt;

  assign hd_valid = !iq_empty;
  assign hd_is_wr = goes_to_buffer(hd_kind, hd_pf);

  // drain owns the first free slot; a read takes what is left
  assign drain   = (st_cnt != '0) && (l2_space_i != 2'd0);
  assign rd_room = (l2_space_i >= 2'd2) || (l2_space_i == 2'd1 && !drain);
  assign wr_take = hd_valid && hd_is_wr && ((st_cnt != OCC_W'(WB_DEPTH)) || drain);
  assign rd_fwd  = hd_valid && !hd_is_wr && !look_hit && rd_room;
  assign iq_pop  = wr_take || rd_fwd;

  wbuf_store #(
    .AW(AW), .DW(DW), .DEPTH(WB_DEPTH), .L1_OFS(L1_OFS), .L2_OFS(L2_OFS)
  ) u_store (
    .clk_i, .rst_ni,
    .push_i(wr_take), .push_addr_i(hd_addr), .push_data_i(hd_data),
    .push_rmw_i(hd_kind == RQ_RMW),
    .pop_i(drain), .look_addr_i(hd_addr),
    .snoop_valid_i, .snoop_addr_i,
    .head_addr_o(l2_wr_addr_o), .head_data_o(l2_wr_data_o), .head_rmw_o(l2_wr_rmw_o),
    .cnt_o(st_cnt), .look_hit_o(look_hit), .snoop_hit_o,
    .cohe_cnt_o
  );

  assign l2_wr_valid_o = drain;
  assign l2_rd_valid_o = rd_fwd;
  assign l2_rd_kind_o  = hd_kind;
  assign l2_rd_pf_o    = hd_pf;
  assign l2_rd_addr_o  = hd_addr;
  assign l2_rd_data_o  = hd_data;
  assign occ_o         = st_cnt;

  logic full_hold, match_hold;
  assign full_hold  = hd_valid && hd_is_wr && !wr_take;
  assign match_hold = hd_valid && !hd_is_wr && look_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stall_full_o  <= '0;
      stall_match_o <= '0;
    end else begin
      if (full_hold && stall_full_o != '1)   stall_full_o  <= stall_full_o + 1'b1;
      if (match_hold && stall_match_o != '1) stall_match_o <= stall_match_o + 1'b1;
    end
  end
endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk #(
  parameter int DEPTH = 8
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [1:0]                   l2_space_i,
  input logic                         l2_wr_valid_o,
  input logic                         l2_rd_valid_o,
  input logic                         snoop_hit_o,
  input logic [$clog2(DEPTH+1)-1:0]   occ_o,
  input logic [$clog2(DEPTH+1)-1:0]   cohe_cnt_o
);
  localparam int CW = $clog2(DEPTH + 1);

  assert_occ_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_o <= CW'(DEPTH));

  assert_wr_needs_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_wr_valid_o |-> (l2_space_i != 2'd0));

  assert_rd_needs_slot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_rd_valid_o |-> (l2_space_i != 2'd0));

  assert_dual_needs_two_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l2_wr_valid_o && l2_rd_valid_o) |-> (l2_space_i >= 2'd2));

  assert_occ_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (occ_o == $past(occ_o)) || (occ_o == $past(occ_o) + 1'b1) ||
             (occ_o == $past(occ_o) - 1'b1));

  assert_cohe_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cohe_cnt_o <= occ_o);

  assert_snoop_marks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_hit_o |=> (cohe_cnt_o != '0));
endmodule

bind l1_write_buffer wbuf_chk #(.DEPTH(WB_DEPTH)) u_chk (.*);

// File: tb/tb_l1_write_buffer.sv
module tb_l1_write_buffer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [1:0]  req_kind_i = '0;
  logic        req_pf_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [31:0] req_data_i = '0;
  logic [1:0]  l2_space_i = '0;
  logic        l2_wr_valid_o, l2_wr_rmw_o;
  logic [31:0] l2_wr_addr_o, l2_wr_data_o;
  logic        l2_rd_valid_o, l2_rd_pf_o;
  logic [1:0]  l2_rd_kind_o;
  logic [31:0] l2_rd_addr_o, l2_rd_data_o;
  logic        snoop_valid_i = 1'b0;
  logic [31:0] snoop_addr_i = '0;
  logic        snoop_hit_o;
  logic [3:0]  occ_o, cohe_cnt_o;
  logic [15:0] stall_full_o, stall_match_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk_i = ~clk_i;

  l1_write_buffer dut (.*);

  task automatic ck(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with valid dropped
  task automatic push(input logic [1:0] k, input logic pf, input logic [31:0] a);
    req_valid_i = 1'b1;
    req_kind_i  = k;
    req_pf_i    = pf;
    req_addr_i  = a;
    req_data_i  = a ^ 32'h5A5A_0000;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
    #1;
  endtask

  task automatic flush();
    l2_space_i = 2'd2;
    idle(50);
  endtask

  task automatic t_reset();
    ck("R1 ready", req_ready_o, 1);
    ck("R1 occ", occ_o, 0);
    ck("R1 cohe", cohe_cnt_o, 0);
    ck("R1 stall_full", stall_full_o, 0);
    ck("R1 stall_match", stall_match_o, 0);
    ck("R1 lanes", {l2_wr_valid_o, l2_rd_valid_o}, 0);
  endtask

  task automatic t_drain_order();
    l2_space_i = 2'd0;
    push(2'd1, 1'b0, 32'h100);
    push(2'd2, 1'b0, 32'h200);
    idle(2);
    ck("R11 occ after two writes", occ_o, 2);
    ck("R4 no drain without space", l2_wr_valid_o, 0);
    l2_space_i = 2'd1;
    #1;
    ck("R4 first drain valid", l2_wr_valid_o, 1);
    ck("R4 first drain addr", l2_wr_addr_o, 32'h100);
    ck("R4 first drain data", l2_wr_data_o, 32'h5A5A_0100);
    ck("R4 first drain rmw", l2_wr_rmw_o, 0);
    idle(1);
    ck("R4 second drain addr", l2_wr_addr_o, 32'h200);
    ck("R4 second drain rmw", l2_wr_rmw_o, 1);
    ck("R11 occ after one drain", occ_o, 1);
    idle(1);
    ck("R11 occ empty", occ_o, 0);
    ck("R4 lane idle", l2_wr_valid_o, 0);
    flush();
  endtask

  task automatic t_classify();
    l2_space_i = 2'd2;
    push(2'd0, 1'b0, 32'h300);
    ck("R2 read on read lane", l2_rd_valid_o, 1);
    ck("R2 read kind", l2_rd_kind_o, 0);
    ck("R2 read addr", l2_rd_addr_o, 32'h300);
    push(2'd3, 1'b0, 32'h310);
    ck("R2 other on read lane", {l2_rd_valid_o, l2_rd_kind_o}, {1'b1, 2'd3});
    push(2'd1, 1'b1, 32'h320);
    ck("R2 prefetch store on read lane", {l2_rd_valid_o, l2_rd_pf_o, l2_rd_kind_o}, {1'b1, 1'b1, 2'd1});
    ck("R2 prefetch store not buffered", occ_o, 0);
    push(2'd2, 1'b0, 32'h330);
    ck("R2 rmw not on read lane", l2_rd_valid_o, 0);
    idle(1);
    ck("R2 rmw drained as write", {l2_wr_valid_o, l2_wr_rmw_o, l2_wr_addr_o}, {1'b1, 1'b1, 32'h330});
    flush();
  endtask

  task automatic t_match_stall();
    logic [15:0] sm;
    l2_space_i = 2'd0;
    push(2'd1, 1'b0, 32'h1000);
    push(2'd0, 1'b0, 32'h1004);
    sm = stall_match_o;
    idle(4);
    ck("R6 match stall count", stall_match_o - sm, 4);
    ck("R6 read held", l2_rd_valid_o, 0);
    l2_space_i = 2'd1;
    #1;
    ck("R5 drain takes only slot", {l2_wr_valid_o, l2_rd_valid_o}, 2'b10);
    idle(1);
    ck("R6 read released after drain", {l2_rd_valid_o, l2_rd_addr_o}, {1'b1, 32'h1004});
    flush();
  endtask

  task automatic t_same_cycle();
    l2_space_i = 2'd0;
    push(2'd1, 1'b0, 32'h2000);
    push(2'd0, 1'b0, 32'h2008);
    l2_space_i = 2'd2;
    #1;
    ck("R7 drain and read together", {l2_wr_valid_o, l2_rd_valid_o}, 2'b11);
    ck("R7 read addr", l2_rd_addr_o, 32'h2008);
    flush();
  endtask

  task automatic t_no_match();
    logic [15:0] sm;
    l2_space_i = 2'd0;
    push(2'd1, 1'b0, 32'h3000);
    push(2'd0, 1'b0, 32'h3020);
    sm = stall_match_o;
    idle(3);
    ck("R6 next block not stalled", stall_match_o - sm, 0);
    ck("R5 no read without space", l2_rd_valid_o, 0);
    l2_space_i = 2'd2;
    #1;
    ck("R5 read with two slots", {l2_wr_valid_o, l2_rd_valid_o, l2_rd_addr_o}, {2'b11, 32'h3020});
    flush();
  endtask

  task automatic t_full();
    logic [15:0] sf;
    l2_space_i = 2'd0;
    for (int i = 0; i < 9; i++) push(2'd1, 1'b0, 32'hA000 + 32'(i) * 32'h100);
    sf = stall_full_o;
    idle(3);
    ck("R3 fifo holds eight", occ_o, 8);
    ck("R8 full stall count", stall_full_o - sf, 3);
    l2_space_i = 2'd1;
    for (int i = 0; i < 9; i++) begin
      #1;
      ck("R4 full drain order", {l2_wr_valid_o, l2_wr_addr_o}, {1'b1, 32'hA000 + 32'(i) * 32'h100});
      @(negedge clk_i);
      if (i == 0) ck("R8 enqueue with drain", occ_o, 8);
    end
    #1;
    ck("R11 occ after full drain", occ_o, 0);
    flush();
  endtask

  task automatic t_inq_full();
    l2_space_i = 2'd0;
    for (int i = 0; i < 39; i++) push(2'd1, 1'b0, 32'h10_0000 + 32'(i) * 32'h40);
    ck("R3 ready with 31 queued", req_ready_o, 1);
    push(2'd1, 1'b0, 32'h20_0000);
    ck("R3 ready low at 32", req_ready_o, 0);
    flush();
    ck("R3 ready after drain", req_ready_o, 1);
    ck("R3 occ after drain", occ_o, 0);
  endtask

  task automatic t_snoop();
    l2_space_i = 2'd0;
    push(2'd1, 1'b0, 32'h4000);
    push(2'd1, 1'b0, 32'h4040);
    push(2'd1, 1'b0, 32'h5000);
    idle(2);
    snoop_valid_i = 1'b1;
    snoop_addr_i  = 32'h4010;
    #1;
    ck("R9 snoop hit", snoop_hit_o, 1);
    idle(1);
    ck("R9 mark count", cohe_cnt_o, 1);
    idle(1);
    ck("R9 repeat snoop no recount", cohe_cnt_o, 1);
    snoop_addr_i = 32'h4800;
    #1;
    ck("R9 other block misses", snoop_hit_o, 0);
    snoop_addr_i = 32'h5050;
    #1;
    ck("R9 coarse block hits", snoop_hit_o, 1);
    idle(1);
    snoop_valid_i = 1'b0;
    ck("R9 second mark", cohe_cnt_o, 2);
    l2_space_i = 2'd1;
    idle(1);
    ck("R10 marked drain decrements", cohe_cnt_o, 1);
    idle(1);
    ck("R10 unmarked drain keeps", cohe_cnt_o, 1);
    idle(1);
    ck("R10 last marked drain", cohe_cnt_o, 0);
    flush();
  endtask

  task automatic t_order();
    l2_space_i = 2'd0;
    push(2'd0, 1'b0, 32'h7000);
    push(2'd1, 1'b0, 32'h8000);
    idle(3);
    ck("R12 write stays behind read", occ_o, 0);
    l2_space_i = 2'd2;
    #1;
    ck("R12 read leaves first", {l2_rd_valid_o, l2_rd_addr_o}, {1'b1, 32'h7000});
    idle(1);
    ck("R12 write not yet out", l2_wr_valid_o, 0);
    idle(1);
    ck("R12 write follows", {l2_wr_valid_o, l2_wr_addr_o}, {1'b1, 32'h8000});
    flush();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    t_reset();
    t_drain_order();
    t_classify();
    t_match_stall();
    t_same_cycle();
    t_no_match();
    t_full();
    t_inq_full();
    t_snoop();
    t_order();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule